// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading one translation entry per level from a four-level table tree held in memory. A request carries the virtual address, whether the access is a write, an instruction fetch or a user-mode access, and is walked from the root table base. Each step reads one 8-byte entry through a single memory port with valid/ready handshakes. The walk ends with a physical address, a page size and the merged permissions, or with a fault code and the level at which the walk stopped.

Two shortcuts are built in. A third-level or second-level entry can map a large page directly (1 GB or 2 MB), which ends the walk early. A caller holding a cached intermediate entry can start the walk below the root by supplying the starting level, the table base and the permissions already merged from the levels above. The walker keeps the accessed and dirty flags up to date by writing back an entry only when a flag it must set is still clear.

Levels are numbered 3 (root) down to 0 (last table) throughout.

Top module: `ptw_walker`

## Requirements
- R1: The entry read at level L is at address {table base with bits [11:0] cleared} + 8 × index, where the index is virtual address bits [20:12] at level 0, [29:21] at level 1, [38:30] at level 2 and [47:39] at level 3; every memory address is a multiple of 8; an idle walker starts at level 3 with the root base.
- R2: Entry encoding: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bit 7 large-page, bit 63 execute-disable, bits [PA_W-1:12] next table or page base; a non-leaf entry hands its base to the next lower level.
- R3: An entry with present = 0 ends the walk with fault = 1, fault_kind = 1 and fault_level equal to that entry's level, and no further memory access for that walk.
- R4: A leaf ends the walk: at level 2 with bit 7 set, a 1 GB page (page_size = 2, pa = entry[PA_W-1:30] joined to va[29:0]); at level 1 with bit 7 set, a 2 MB page (page_size = 1, pa = entry[PA_W-1:21] joined to va[20:0]); at level 0 always a 4 KB page (page_size = 0, pa = entry[PA_W-1:12] joined to va[11:0]). Bit 7 at level 3 is ignored.
- R5: The reported writable and user permissions are the AND of those bits over every level visited, and execute-disable is the OR.
- R6: At the leaf, a write without merged writable, a fetch with merged execute-disable, or a user access without merged user ends the walk with fault_kind = 2 at the leaf's level; the faulting leaf is not written back.
- R7: Each non-faulting entry whose accessed bit is clear is written back to its own address with the accessed bit set, as a separate 8-byte write; an entry whose accessed bit is already set is not written.
- R8: On a write access the leaf's dirty bit is set in the same write-back; a leaf already marked accessed and dirty causes no write. Flags are never cleared.
- R9: With skip_valid set at request time, the walk starts at skip_level with skip_base and seeds the merged permissions with skip_w, skip_u and skip_xd; entries above that level are not read.
- R10: req_ready is high only while idle and no memory request is issued while idle; a memory request holds its address, write flag and data until accepted, and at most one request is outstanding.
- R11: done is a one-cycle pulse in the cycle after the response that finished the walk; fault, fault_kind, fault_level, pa_out, page_size and the permission outputs are valid while done is high.
- R12: After reset done and mem_req_valid are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is from user mode |
| root_base | input | PA_W | Physical base of the root table |
| skip_valid | input | 1 | Start below the root |
| skip_level | input | 2 | Starting level when skipping |
| skip_base | input | PA_W | Table base at the starting level |
| skip_w | input | 1 | Merged writable from the skipped levels |
| skip_u | input | 1 | Merged user from the skipped levels |
| skip_xd | input | 1 | Merged execute-disable from the skipped levels |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Entry address |
| mem_req_we | output | 1 | Request is a flag write-back |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_data | input | 64 | Entry value read |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_kind | output | 2 | 1 not present, 2 protection |
| fault_level | output | 2 | Level at which the walk faulted |
| pa_out | output | PA_W | Translated physical address |
| page_size | output | 2 | 0 4 KB, 1 2 MB, 2 1 GB |
| perm_w | output | 1 | Merged writable |
| perm_u | output | 1 | Merged user |
| perm_xd | output | 1 | Merged execute-disable |

## Verification
Every walk result appears exactly one cycle after the memory response that decides it, so the bench polls done on the falling edge after each rising edge and takes every result in the one cycle where done is high, then confirms done has dropped one cycle later. Memory ready toggles every cycle and the memory answers one cycle after accepting, so walks take a varying number of cycles and the bench never counts cycles to a result; it instead counts entry reads and flag writes per walk and compares them with the levels each walk must visit and the flags it must set. The flag write-backs themselves are checked by reading the bench memory after the vector run.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 48;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 9;
    localparam int NUM_LVL   = 4;
    localparam int LVL_W     = $clog2(NUM_LVL);
    localparam int PTE_W     = 64;
    localparam int ENT_SHIFT = $clog2(PTE_W / 8);
    localparam int MID_OFF_W = OFF_W + IDX_W;          // 2 MB page offset width
    localparam int BIG_OFF_W = OFF_W + 2 * IDX_W;      // 1 GB page offset width

    // entry bit positions
    localparam int B_PRES = 0;
    localparam int B_WR   = 1;
    localparam int B_USR  = 2;
    localparam int B_ACC  = 5;
    localparam int B_DIRT = 6;
    localparam int B_BIG  = 7;
    localparam int B_NOX  = 63;

    localparam logic [1:0] FK_NONE = 2'd0;
    localparam logic [1:0] FK_NP   = 2'd1;
    localparam logic [1:0] FK_PROT = 2'd2;

    localparam logic [1:0] SZ_4K = 2'd0;
    localparam logic [1:0] SZ_2M = 2'd1;
    localparam logic [1:0] SZ_1G = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  addr
);
    logic [IDX_W-1:0] idx_by_lvl [NUM_LVL];

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_idx
            assign idx_by_lvl[g] = vaddr[OFF_W + IDX_W * g +: IDX_W];
        end
    endgenerate

    logic [PA_W-1:0] base_al;
    logic [PA_W-1:0] idx_off;

    assign base_al = {base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    assign idx_off = PA_W'({idx_by_lvl[level], {ENT_SHIFT{1'b0}}});
    assign addr    = base_al + idx_off;
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
    import ptw_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [PTE_W-1:0]     ent,
    input  logic [LVL_W-1:0]     level,
    input  logic [BIG_OFF_W-1:0] va_low,
    input  logic                 acc_wr,
    input  logic                 acc_fx,
    input  logic                 acc_us,
    input  logic                 in_w,
    input  logic                 in_u,
    input  logic                 in_xd,
    output logic                 present,
    output logic                 leaf,
    output logic                 m_w,
    output logic                 m_u,
    output logic                 m_xd,
    output logic                 prot,
    output logic                 need_wr,
    output logic [PTE_W-1:0]     wdata,
    output logic [PA_W-1:0]      pa,
    output logic [1:0]           size,
    output logic [PA_W-1:0]      next_base
);
    logic set_dirty;
    logic unused_ent;

    assign unused_ent = ^{ent[PTE_W-2:PA_W], ent[OFF_W-1:B_BIG+1], ent[B_ACC-1:B_USR+1]};

    assign present = ent[B_PRES];
    assign leaf    = (level == LVL_W'(0)) ||
                     (ent[B_BIG] && ((level == LVL_W'(1)) || (level == LVL_W'(2))));

    assign m_w  = in_w & ent[B_WR];
    assign m_u  = in_u & ent[B_USR];
    assign m_xd = in_xd | ent[B_NOX];

    assign prot = (acc_wr & ~m_w) | (acc_fx & m_xd) | (acc_us & ~m_u);

    assign set_dirty = leaf & acc_wr & ~ent[B_DIRT];
    assign need_wr   = ~ent[B_ACC] | set_dirty;

    always_comb begin
        wdata          = ent;
        wdata[B_ACC]   = 1'b1;
        wdata[B_DIRT]  = ent[B_DIRT] | (leaf & acc_wr);
    end

    assign next_base = {ent[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        case (level)
            LVL_W'(2): begin
                pa   = {ent[PA_W-1:BIG_OFF_W], va_low[BIG_OFF_W-1:0]};
                size = SZ_1G;
            end
            LVL_W'(1): begin
                pa   = {ent[PA_W-1:MID_OFF_W], va_low[MID_OFF_W-1:0]};
                size = SZ_2M;
            end
            default: begin
                pa   = {ent[PA_W-1:OFF_W], va_low[OFF_W-1:0]};
                size = SZ_4K;
            end
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 req_write,
    input  logic                 req_fetch,
    input  logic                 req_user,
    input  logic [PA_W-1:0]      root_base,
    input  logic                 skip_valid,
    input  logic [LVL_W-1:0]     skip_level,
    input  logic [PA_W-1:0]      skip_base,
    input  logic                 skip_w,
    input  logic                 skip_u,
    input  logic                 skip_xd,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PA_W-1:0]      mem_req_addr,
    output logic                 mem_req_we,
    output logic [PTE_W-1:0]     mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [PTE_W-1:0]     mem_rsp_data,
    output logic                 done,
    output logic                 fault,
    output logic [1:0]           fault_kind,
    output logic [LVL_W-1:0]     fault_level,
    output logic [PA_W-1:0]      pa_out,
    output logic [1:0]           page_size,
    output logic                 perm_w,
    output logic                 perm_u,
    output logic                 perm_xd
);
    typedef struct packed {
        walk_st_e         st;
        logic [LVL_W-1:0] lvl;
        logic [PA_W-1:0]  base;
        logic [VA_W-1:0]  va;
        logic             wr;
        logic             fx;
        logic             us;
        logic             mw;
        logic             mu;
        logic             mx;
        logic [PTE_W-1:0] ent;
        logic             leaf_hit;
        logic             flt;
        logic [1:0]       fkind;
        logic [LVL_W-1:0] flvl;
        logic [1:0]       size;
        logic [PA_W-1:0]  pa;
    } walk_s;

    walk_s d, q;

    logic [PA_W-1:0]  ent_addr;
    logic             ev_present, ev_leaf, ev_w, ev_u, ev_xd, ev_prot, ev_need_wr;
    logic [PTE_W-1:0] ev_wdata;
    logic [PA_W-1:0]  ev_pa, ev_next_base;
    logic [1:0]       ev_size;

    ptw_addr_gen #(.PA_W(PA_W)) addr_i (
        .base  (q.base),
        .vaddr (q.va),
        .level (q.lvl),
        .addr  (ent_addr)
    );

    ptw_leaf_eval #(.PA_W(PA_W)) eval_i (
        .ent       (mem_rsp_data),
        .level     (q.lvl),
        .va_low    (q.va[BIG_OFF_W-1:0]),
        .acc_wr    (q.wr),
        .acc_fx    (q.fx),
        .acc_us    (q.us),
        .in_w      (q.mw),
        .in_u      (q.mu),
        .in_xd     (q.mx),
        .present   (ev_present),
        .leaf      (ev_leaf),
        .m_w       (ev_w),
        .m_u       (ev_u),
        .m_xd      (ev_xd),
        .prot      (ev_prot),
        .need_wr   (ev_need_wr),
        .wdata     (ev_wdata),
        .pa        (ev_pa),
        .size      (ev_size),
        .next_base (ev_next_base)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va       = req_vaddr;
                    d.wr       = req_write;
                    d.fx       = req_fetch;
                    d.us       = req_user;
                    d.flt      = 1'b0;
                    d.fkind    = FK_NONE;
                    d.flvl     = '0;
                    d.leaf_hit = 1'b0;
                    if (skip_valid) begin
                        d.lvl  = skip_level;
                        d.base = skip_base;
                        d.mw   = skip_w;
                        d.mu   = skip_u;
                        d.mx   = skip_xd;
                    end else begin
                        d.lvl  = LVL_W'(NUM_LVL - 1);
                        d.base = root_base;
                        d.mw   = 1'b1;
                        d.mu   = 1'b1;
                        d.mx   = 1'b0;
                    end
                    d.st = ST_RD_REQ;
                end
            end
            ST_RD_REQ: begin
                if (mem_req_ready) d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ev_present) begin
                        d.flt   = 1'b1;
                        d.fkind = FK_NP;
                        d.flvl  = q.lvl;
                        d.st    = ST_DONE;
                    end else begin
                        d.mw = ev_w;
                        d.mu = ev_u;
                        d.mx = ev_xd;
                        if (ev_leaf && ev_prot) begin
                            d.flt   = 1'b1;
                            d.fkind = FK_PROT;
                            d.flvl  = q.lvl;
                            d.st    = ST_DONE;
                        end else begin
                            d.ent      = ev_wdata;
                            d.leaf_hit = ev_leaf;
                            if (ev_leaf) begin
                                d.pa   = ev_pa;
                                d.size = ev_size;
                            end
                            if (ev_need_wr) begin
                                d.st = ST_WR_REQ;
                            end else if (ev_leaf) begin
                                d.st = ST_DONE;
                            end else begin
                                d.lvl  = q.lvl - LVL_W'(1);
                                d.base = ev_next_base;
                                d.st   = ST_RD_REQ;
                            end
                        end
                    end
                end
            end
            ST_WR_REQ: begin
                if (mem_req_ready) d.st = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (q.leaf_hit) begin
                        d.st = ST_DONE;
                    end else begin
                        d.lvl  = q.lvl - LVL_W'(1);
                        d.base = {q.ent[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                        d.st   = ST_RD_REQ;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_RD_REQ) || (q.st == ST_WR_REQ);
    assign mem_req_we    = (q.st == ST_WR_REQ);
    assign mem_req_addr  = ent_addr;
    assign mem_req_wdata = q.ent;
    assign done          = (q.st == ST_DONE);
    assign fault         = done & q.flt;
    assign fault_kind    = q.fkind;
    assign fault_level   = q.flvl;
    assign pa_out        = q.pa;
    assign page_size     = q.size;
    assign perm_w        = q.mw;
    assign perm_u        = q.mu;
    assign perm_xd       = q.mx;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
#(
    parameter int PA_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_req_we,
    input logic [PTE_W-1:0] mem_req_wdata,
    input logic             mem_rsp_valid,
    input logic             done,
    input logic             fault,
    input logic [1:0]       fault_kind
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n)                             outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid)                 outstanding <= 1'b0;
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata));

    // R10
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // R1
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

    // R7
    writeback_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[B_ACC]);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_rsp_valid));

    // R3
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_kind != FK_NONE);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_we    (mem_req_we),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .fault_kind    (fault_kind)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
    localparam int PA_W = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [47:0]     req_vaddr = '0;
    logic            req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
    logic [PA_W-1:0] root_base = 40'h1000;
    logic            skip_valid = 1'b0;
    logic [1:0]      skip_level = '0;
    logic [PA_W-1:0] skip_base = '0;
    logic            skip_w = 1'b0, skip_u = 1'b0, skip_xd = 1'b0;
    logic            mem_req_valid, mem_req_we;
    logic            mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic [63:0]     mem_req_wdata;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            done, fault, perm_w, perm_u, perm_xd;
    logic [1:0]      fault_kind, fault_level, page_size;
    logic [PA_W-1:0] pa_out;

    always #5 clk = ~clk;

    ptw_walker #(.PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_fetch(req_fetch),
        .req_user(req_user), .root_base(root_base), .skip_valid(skip_valid),
        .skip_level(skip_level), .skip_base(skip_base), .skip_w(skip_w),
        .skip_u(skip_u), .skip_xd(skip_xd), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_we(mem_req_we), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_kind(fault_kind),
        .fault_level(fault_level), .pa_out(pa_out), .page_size(page_size),
        .perm_w(perm_w), .perm_u(perm_u), .perm_xd(perm_xd)
    );

    // sparse table memory; built while reset is held
    logic [63:0] mem [logic [PA_W-1:0]];
    int rd_cnt = 0;
    int wr_cnt = 0;

    function automatic logic [63:0] peek(input logic [PA_W-1:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_req_ready <= ~mem_req_ready;
        if (!rst_n) begin
            mem[40'h1008] = 64'h0000_0000_0000_2007;
            mem[40'h1010] = 64'h0000_0000_0000_8003;
            mem[40'h2010] = 64'h0000_0000_0000_3007;
            mem[40'h2028] = 64'h0000_0000_C000_00A7;
            mem[40'h3018] = 64'h0000_0000_0000_4007;
            mem[40'h3030] = 64'h0000_0080_0020_0087;
            mem[40'h3038] = 64'h0000_0000_0000_5005;
            mem[40'h3040] = 64'h8000_0000_0000_6007;
            mem[40'h4020] = 64'h0000_0000_ABCD_E007;
            mem[40'h5000] = 64'h0000_0000_7000_0007;
            mem[40'h6008] = 64'h0000_0000_9000_0007;
            mem[40'h8000] = 64'h0000_0000_4000_0087;
        end else if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                rd_cnt = rd_cnt + 1;
            end
            mem_rsp_data  <= peek(mem_req_addr);
            mem_rsp_valid <= 1'b1;
        end
    end

    typedef struct packed {
        logic [47:0]     va;
        logic            wr, fx, us, sk;
        logic [1:0]      skl;
        logic [PA_W-1:0] skb;
        logic            skw, sku, skx;
        logic            ef;
        logic [1:0]      ek, el;
        logic [PA_W-1:0] epa;
        logic [1:0]      esz;
        logic            ew, eu, ex;
        logic [3:0]      erd, ewr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R1 R2 R7: 4 KB walk from the root, all four entries gain accessed
        '{48'h0080_8060_4123, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_ABCD_E123, 2'd0, 1'b1,1'b1,1'b0, 4'd4,4'd0 + 4'd4},
        // R7: same walk again, no write-back
        '{48'h0080_8060_4123, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_ABCD_E123, 2'd0, 1'b1,1'b1,1'b0, 4'd4,4'd0},
        // R8: write sets dirty on the leaf
        '{48'h0080_8060_4123, 1'b1,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_ABCD_E123, 2'd0, 1'b1,1'b1,1'b0, 4'd4,4'd1},
        // R8: dirty already set, no write
        '{48'h0080_8060_4123, 1'b1,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_ABCD_E123, 2'd0, 1'b1,1'b1,1'b0, 4'd4,4'd0},
        // R4: 1 GB page at level 2
        '{48'h0081_5234_5678, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_D234_5678, 2'd2, 1'b1,1'b1,1'b0, 4'd2,4'd0},
        // R4: 2 MB page at level 1
        '{48'h0080_80C1_ABCD, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h80_0021_ABCD, 2'd1, 1'b1,1'b1,1'b0, 4'd3,4'd1},
        // R5: read-only at level 1 merges to perm_w = 0
        '{48'h0080_80E0_0010, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_7000_0010, 2'd0, 1'b0,1'b1,1'b0, 4'd4,4'd2},
        // R6: write through read-only path faults at leaf
        '{48'h0080_80E0_0010, 1'b1,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b1,2'd2,2'd0, 40'h0, 2'd0, 1'b0,1'b0,1'b0, 4'd4,4'd0},
        // R6: fetch under execute-disable faults
        '{48'h0080_8100_1044, 1'b0,1'b1,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b1,2'd2,2'd0, 40'h0, 2'd0, 1'b0,1'b0,1'b0, 4'd4,4'd1},
        // R5: execute-disable ORed from level 1
        '{48'h0080_8100_1044, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_9000_0044, 2'd0, 1'b1,1'b1,1'b1, 4'd4,4'd1},
        // R6: user access to supervisor 1 GB page
        '{48'h0100_0000_0ABC, 1'b0,1'b0,1'b1,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b1,2'd2,2'd2, 40'h0, 2'd0, 1'b0,1'b0,1'b0, 4'd2,4'd1},
        // R5: supervisor read, perm_u = 0
        '{48'h0100_0000_0ABC, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b0,2'd0,2'd0, 40'h00_4000_0ABC, 2'd2, 1'b1,1'b0,1'b0, 4'd2,4'd1},
        // R3: absent root entry
        '{48'h0180_0000_0000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b1,2'd1,2'd3, 40'h0, 2'd0, 1'b0,1'b0,1'b0, 4'd1,4'd0},
        // R3: absent level-1 entry
        '{48'h0080_8120_0000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b1,2'd1,2'd1, 40'h0, 2'd0, 1'b0,1'b0,1'b0, 4'd3,4'd0},
        // R3: absent level-0 entry
        '{48'h0080_8060_5000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 40'h0, 1'b0,1'b0,1'b0, 1'b1,2'd1,2'd0, 40'h0, 2'd0, 1'b0,1'b0,1'b0, 4'd4,4'd0},
        // R9: start at level 0, seeded perm_w = 0
        '{48'h0080_8060_4123, 1'b0,1'b0,1'b0,1'b1, 2'd0, 40'h4000, 1'b0,1'b1,1'b0, 1'b0,2'd0,2'd0, 40'h00_ABCD_E123, 2'd0, 1'b0,1'b1,1'b0, 4'd1,4'd0},
        // R9: start at level 1 with a write
        '{48'h0080_8060_4123, 1'b1,1'b0,1'b0,1'b1, 2'd1, 40'h3000, 1'b1,1'b1,1'b0, 1'b0,2'd0,2'd0, 40'h00_ABCD_E123, 2'd0, 1'b1,1'b1,1'b0, 4'd2,4'd0},
        // R9 R6: seeded read-only makes a 2 MB write fault at level 1
        '{48'h0080_80C1_ABCD, 1'b1,1'b0,1'b0,1'b1, 2'd2, 40'h2000, 1'b0,1'b1,1'b0, 1'b1,2'd2,2'd1, 40'h0, 2'd0, 1'b0,1'b0,1'b0, 4'd2,4'd0}
    };

    int n_total = 0;
    int n_bad   = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_walk(input vec_t v, output bit ok);
        int c;
        @(negedge clk);
        req_vaddr  = v.va;
        req_write  = v.wr;
        req_fetch  = v.fx;
        req_user   = v.us;
        skip_valid = v.sk;
        skip_level = v.skl;
        skip_base  = v.skb;
        skip_w     = v.skw;
        skip_u     = v.sku;
        skip_xd    = v.skx;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        skip_valid = 1'b0;
        c = 0;
        while (!done && c < 300) begin
            @(negedge clk);
            c++;
        end
        ok = done;
    endtask

    initial begin
        #2_000_000;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_total + 1, n_bad + 1);
        $finish;
    end

    initial begin
        bit ok;
        int rd0, wr0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 done low in reset", {63'b0, done}, 64'd0);
        chk("R12 mem_req_valid low in reset", {63'b0, mem_req_valid}, 64'd0);
        chk("R12 req_ready high in reset", {63'b0, req_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", {62'b0, done, mem_req_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v   = VECS[i];
            rd0 = rd_cnt;
            wr0 = wr_cnt;
            run_walk(v, ok);
            if (!ok) begin
                chk($sformatf("R11 vec%0d done timeout", i), 64'd0, 64'd1);
                continue;
            end
            // R3 R6: fault flag and code; R4 R5: translation and merged perms
            chk($sformatf("R3 R6 vec%0d fault", i), {63'b0, fault}, {63'b0, v.ef});
            if (v.ef) begin
                chk($sformatf("R3 R6 vec%0d fault_kind", i), {62'b0, fault_kind}, {62'b0, v.ek});
                chk($sformatf("R3 R6 vec%0d fault_level", i), {62'b0, fault_level}, {62'b0, v.el});
            end else begin
                chk($sformatf("R1 R4 vec%0d pa_out", i), {24'b0, pa_out}, {24'b0, v.epa});
                chk($sformatf("R4 vec%0d page_size", i), {62'b0, page_size}, {62'b0, v.esz});
                chk($sformatf("R5 vec%0d perms", i), {61'b0, perm_w, perm_u, perm_xd},
                    {61'b0, v.ew, v.eu, v.ex});
            end
            // R7 R8 R9: entries visited and flag writes issued
            chk($sformatf("R9 vec%0d entry reads", i), 64'(rd_cnt - rd0), 64'(v.erd));
            chk($sformatf("R7 R8 vec%0d flag writes", i), 64'(wr_cnt - wr0), 64'(v.ewr));
            @(negedge clk);
            // R11: done lasts one cycle, walker idle again
            chk($sformatf("R11 vec%0d done pulse", i), {62'b0, done, req_ready}, 64'd1);
        end

        // R8: leaf of the 4 KB path holds accessed and dirty
        chk("R8 leaf flags after write", peek(40'h4020), 64'h0000_0000_ABCD_E067);
        // R6: faulting write left the read-only leaf without dirty
        chk("R6 no dirty on faulting leaf", peek(40'h5000), 64'h0000_0000_7000_0027);
        // R7: execute-disable entry written with accessed, other bits kept
        chk("R7 accessed on level-1 entry", peek(40'h3040), 64'h8000_0000_0000_6027);
        // R7: entry with accessed already set left untouched
        chk("R7 untouched 1 GB entry", peek(40'h2028), 64'h0000_0000_C000_00A7);
        // R3: absent root entry never written
        chk("R3 absent entry unwritten", {63'b0, mem.exists(40'h1018)}, 64'd0);
        // R2: intermediate entries keep their base, only accessed added
        chk("R2 root entry base kept", peek(40'h1008), 64'h0000_0000_0000_2027);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule